// File: doc/BRIEF.md
# Programmable LCD Raster Timing Generator

This block generates the raster timing a TFT-style panel expects. It makes a panel clock, horizontal and vertical sync, a data-enable and the pixel column and row of the current active pixel. Software sets the timing through a small register port. There are three timing words, a control word, an interrupt enable mask, a raw status register and a masked status view.

A line runs through four phases in this order: sync, back porch, active pixels, front porch. A frame runs through the same four phases, counted in lines. Most length fields hold their value minus one. The clock divisor holds its ratio minus two. The line length is kept in units of 16 pixels. The vertical sync and porch fields hold plain line counts, so they may be zero.

An interrupt can be raised at one of four vertical phases. Three further status bits are set by pulses arriving from outside the block.

Top module: `lcd_raster_timer`

## Requirements
- R1: After reset, or while control bit 0 is clear, the counters stay at zero. While disabled, hsync, vsync, de and the panel clock rest at their inactive levels, and px_x and px_y are 0.
- R2: Horizontal timing word (address 0) layout: bits 15:8 hold the sync width minus one, bits 31:24 the back porch minus one, bits 23:16 the front porch minus one, and bits 7:2 hold (pixels per line / 16) minus one. hsync is active for the sync width at the start of each line, and the line length is the sum of the four phases.
- R3: Vertical timing word (address 1) layout: bits 15:10 hold the sync lines, bits 31:24 the back porch lines and bits 23:16 the front porch lines, each taken as stored. Bits 9:0 hold the active lines minus one. vsync is active during the sync lines at the start of each frame.
- R4: de is active only when both the pixel and the line are in their active regions. While de is active, px_x and px_y count from 0 at the first active pixel and line; otherwise both are 0.
- R5: In the clock word (address 2), setting bit 12 makes hsync active low, bit 11 makes vsync active low, bit 14 inverts de and bit 13 inverts the panel clock.
- R6: Clock word bits 4:0 hold the divide ratio minus two, and the timing advances once per ratio input clocks. When bit 26 is set, the divider is bypassed: the timing advances every clock and the panel clock equals the input clock.
- R7: Control bits 13:12 (address 3) select when raw status bit 3 is set: 0 at the start of vertical sync, 1 at the start of the back porch, 2 at the start of the active lines, 3 at the start of the front porch.
- R8: Raw status (address 5) bits are 4 bus error, 3 vertical compare, 2 base update and 1 underflow. Bits 4, 2 and 1 are set by input pulses. The masked status (address 6) is raw AND enable (address 4), and irq is the OR of the masked bits.
- R9: Writing a one to a raw status bit clears it. When an event and a clear of the same bit occur in the same cycle, the bit stays set.
- R10: Each register reads back on reg_rdata one clock after its address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| ev_bus_err | input | 1 | Sets raw status bit 4 |
| ev_base_upd | input | 1 | Sets raw status bit 2 |
| ev_underrun | input | 1 | Sets raw status bit 1 |
| pclk | output | 1 | Panel clock |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| px_x | output | XW | Active pixel column |
| px_y | output | YW | Active line row |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a status bit receiving an event pulse and a write-one-to-clear in the same clock. The bench drives an external event and a clear write to the same bit on one edge, then reads the raw status back. Each vertical-compare phase is tested from a freshly re-enabled raster, so the bench can predict the exact sample at which irq rises. The bench also sweeps whole frames, cycle by cycle, against an arithmetic model. One configuration has zero-length vertical phases, inverted polarities and the divider in use.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  typedef enum logic [2:0] {
    A_HTIM = 3'd0,
    A_VTIM = 3'd1,
    A_CLKW = 3'd2,
    A_CTRL = 3'd3,
    A_IEN  = 3'd4,
    A_RAW  = 3'd5,
    A_MSK  = 3'd6
  } lcdt_addr_e;

  localparam int SW = 4;  // status bits 4..1
endpackage

// File: rtl/lcdt_regs.sv
module lcdt_regs
  import lcdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  input  logic [4:1]  set_vec,
  output logic [31:0] htim,
  output logic [31:0] vtim,
  output logic [31:0] clkw,
  output logic [31:0] ctrl,
  output logic [31:0] rdata,
  output logic        irq
);
  logic [4:1] ien, raw, clr;

  assign clr = (we && addr == A_RAW) ? wdata[4:1] : '0;
  assign irq = |(raw & ien);

  always_ff @(posedge clk) begin
    if (rst) begin
      htim <= '0; vtim <= '0; clkw <= '0; ctrl <= '0;
      ien <= '0; raw <= '0; rdata <= '0;
    end else begin
      if (we) begin
        case (addr)
          A_HTIM:  htim <= wdata;
          A_VTIM:  vtim <= wdata;
          A_CLKW:  clkw <= wdata;
          A_CTRL:  ctrl <= wdata;
          A_IEN:   ien  <= wdata[4:1];
          default: ;
        endcase
      end
      raw <= (raw & ~clr) | set_vec;
      case (addr)
        A_HTIM:  rdata <= htim;
        A_VTIM:  rdata <= vtim;
        A_CLKW:  rdata <= clkw;
        A_CTRL:  rdata <= ctrl;
        A_IEN:   rdata <= {27'd0, ien, 1'b0};
        A_RAW:   rdata <= {27'd0, raw, 1'b0};
        A_MSK:   rdata <= {27'd0, raw & ien, 1'b0};
        default: rdata <= '0;
      endcase
    end
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((raw & $past(set_vec)) == $past(set_vec)));
  assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
    ((clr & ~set_vec) != '0) |=> ((raw & $past(clr & ~set_vec)) == '0));
  assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (raw != '0 && ien != '0));
endmodule

// File: rtl/lcdt_pixdiv.sv
module lcdt_pixdiv #(
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          bypass,
  input  logic [DW-1:0] div_f,
  output logic          tick,
  output logic          pclk_q
);
  localparam int RW = DW + 1;
  logic [RW-1:0] ratio, cnt;

  assign ratio = RW'(div_f) + RW'(2);
  assign tick  = run && (bypass || cnt == ratio - RW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run || bypass) begin
      cnt    <= '0;
      pclk_q <= 1'b0;
    end else begin
      cnt    <= tick ? '0 : cnt + RW'(1);
      pclk_q <= cnt < (ratio >> 1);
    end
  end

  assert_tick_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !bypass) |=> (!tick || bypass));
endmodule

// File: rtl/lcdt_axis.sv
module lcdt_axis #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic [CW-1:0] l_sync,
  input  logic [CW-1:0] l_bp,
  input  logic [CW-1:0] l_act,
  input  logic [CW-1:0] l_fp,
  output logic [CW-1:0] cnt,
  output logic          last,
  output logic          in_sync,
  output logic          in_act,
  output logic [CW-1:0] pos,
  output logic [CW-1:0] s1,
  output logic [CW-1:0] s2,
  output logic [CW-1:0] s3
);
  logic [CW-1:0] tot;

  assign s1      = l_sync;
  assign s2      = s1 + l_bp;
  assign s3      = s2 + l_act;
  assign tot     = s3 + l_fp;
  assign last    = cnt == tot - CW'(1);
  assign in_sync = cnt < s1;
  assign in_act  = cnt >= s2 && cnt < s3;
  assign pos     = cnt - s2;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (step)   cnt <= last ? '0 : cnt + CW'(1);
  end

  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (!clr && step && last) |=> (cnt == '0));
  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!clr && !step) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcdt_pkg::*;
#(
  parameter int CW = 12,
  parameter int XW = 10,
  parameter int YW = 10,
  parameter int DW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          ev_bus_err,
  input  logic          ev_base_upd,
  input  logic          ev_underrun,
  output logic          pclk,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [XW-1:0] px_x,
  output logic [YW-1:0] px_y,
  output logic          irq
);
  logic [31:0] htim, vtim, clkw, ctrl;
  logic en, byp, ihs, ivs, ipc, ioe, tick, pclk_q, vc_evt, de_act_q;
  logic [CW-1:0] h_cnt, h_pos, h_s1, h_s2, h_s3;
  logic [CW-1:0] v_cnt, v_pos, v_s1, v_s2, v_s3, v_target;
  logic h_last, h_sync, h_act, v_last, v_sync, v_act;
  logic unused_bits;

  assign en  = ctrl[0];
  assign byp = clkw[26];
  assign ioe = clkw[14];
  assign ipc = clkw[13];
  assign ihs = clkw[12];
  assign ivs = clkw[11];
  assign unused_bits = ^{clkw[31:27], clkw[25:15], clkw[10:5], ctrl[31:14],
                         ctrl[11:1], htim[1:0], v_last, h_s3, XW'(0), YW'(0)};

  lcdt_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .set_vec({ev_bus_err, vc_evt, ev_base_upd, ev_underrun}),
    .htim(htim), .vtim(vtim), .clkw(clkw), .ctrl(ctrl),
    .rdata(reg_rdata), .irq(irq)
  );

  lcdt_pixdiv #(.DW(DW)) u_div (
    .clk(clk), .rst(rst), .run(en), .bypass(byp), .div_f(clkw[DW-1:0]),
    .tick(tick), .pclk_q(pclk_q)
  );

  lcdt_axis #(.CW(CW)) u_h (
    .clk(clk), .rst(rst), .clr(!en), .step(tick),
    .l_sync(CW'(htim[15:8]) + CW'(1)), .l_bp(CW'(htim[31:24]) + CW'(1)),
    .l_act(CW'({htim[7:2], 4'b0000}) + CW'(16)), .l_fp(CW'(htim[23:16]) + CW'(1)),
    .cnt(h_cnt), .last(h_last), .in_sync(h_sync), .in_act(h_act),
    .pos(h_pos), .s1(h_s1), .s2(h_s2), .s3(h_s3)
  );

  lcdt_axis #(.CW(CW)) u_v (
    .clk(clk), .rst(rst), .clr(!en), .step(tick && h_last),
    .l_sync(CW'(vtim[15:10])), .l_bp(CW'(vtim[31:24])),
    .l_act(CW'(vtim[9:0]) + CW'(1)), .l_fp(CW'(vtim[23:16])),
    .cnt(v_cnt), .last(v_last), .in_sync(v_sync), .in_act(v_act),
    .pos(v_pos), .s1(v_s1), .s2(v_s2), .s3(v_s3)
  );

  always_comb begin
    case (ctrl[13:12])
      2'd0:    v_target = '0;
      2'd1:    v_target = v_s1;
      2'd2:    v_target = v_s2;
      default: v_target = v_s3;
    endcase
  end

  assign vc_evt = tick && h_cnt == '0 && v_cnt == v_target;
  assign pclk   = ((byp && en) ? clk : pclk_q) ^ ipc;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync <= 1'b0; vsync <= 1'b0; de <= 1'b0; de_act_q <= 1'b0;
      px_x  <= '0;   px_y  <= '0;
    end else begin
      hsync    <= (en && h_sync) ^ ihs;
      vsync    <= (en && v_sync) ^ ivs;
      de_act_q <= en && h_act && v_act;
      de       <= (en && h_act && v_act) ^ ioe;
      px_x     <= (en && h_act && v_act) ? h_pos[XW-1:0] : '0;
      px_y     <= (en && h_act && v_act) ? v_pos[YW-1:0] : '0;
    end
  end

  assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (px_x == '0 && px_y == '0 && !de_act_q));
  assert_xy_only_active_R4: assert property (@(posedge clk) disable iff (rst)
    (px_x != '0 || px_y != '0) |-> de_act_q);
  assert_vcomp_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
    vc_evt |-> (en && h_cnt == '0));
endmodule

// File: tb/test_lcd_raster_timer.sv
module test_lcd_raster_timer;
  logic clk = 0, rst = 1;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic ev_bus_err = 0, ev_base_upd = 0, ev_underrun = 0;
  logic pclk, hsync, vsync, de, irq;
  logic [9:0] px_x, px_y;
  int tests = 0, fails = 0;

  int hsw_f, hbp_f, ppl_f, hfp_f, vsw, vbp, lpp_f, vfp, div_f, byp, ihs, ivs, ioe, ipc;

  always #5 clk = ~clk;

  lcd_raster_timer i_lcd_raster_timer (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_bus_err(ev_bus_err),
    .ev_base_upd(ev_base_upd), .ev_underrun(ev_underrun), .pclk(pclk),
    .hsync(hsync), .vsync(vsync), .de(de), .px_x(px_x), .px_y(px_y), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we = 1; reg_addr = 3'(a); reg_wdata = 32'(d);
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); reg_addr = 3'(a);
    @(negedge clk); d = int'(reg_rdata);
  endtask

  function automatic int hword();
    return (hbp_f << 24) | (hfp_f << 16) | (hsw_f << 8) | (ppl_f << 2);
  endfunction
  function automatic int vword();
    return (vbp << 24) | (vfp << 16) | (vsw << 10) | lpp_f;
  endfunction

  task automatic apply_cfg();
    wr(0, hword());
    wr(1, vword());
    wr(2, (byp << 26) | (ioe << 14) | (ipc << 13) | (ihs << 12) | (ivs << 11) | div_f);
  endtask

  // R2 R3 R4 R5: sample-by-sample comparison against the arithmetic raster model
  task automatic sweep(input int nsamp);
    int hs, hb, ha, htot, vtot, ratio;
    hs = hsw_f + 1; hb = hbp_f + 1; ha = (ppl_f + 1) * 16;
    htot = hs + hb + ha + hfp_f + 1;
    vtot = vsw + vbp + lpp_f + 1 + vfp;
    ratio = byp ? 1 : div_f + 2;
    for (int m = 0; m < nsamp; m++) begin
      int n, h, v, eh, ev, ed, ex, ey;
      bit act;
      @(negedge clk);
      n = m / ratio; h = n % htot; v = (n / htot) % vtot;
      act = (h >= hs + hb) && (h < hs + hb + ha) && (v >= vsw + vbp) && (v < vsw + vbp + lpp_f + 1);
      eh = int'(h < hs) ^ ihs;
      ev = int'(v < vsw) ^ ivs;
      ed = int'(act) ^ ioe;
      ex = act ? h - hs - hb : 0;
      ey = act ? v - vsw - vbp : 0;
      check(hsync === 1'(eh), "R2/R5 hsync", int'(hsync), eh);
      check(vsync === 1'(ev), "R3/R5 vsync", int'(vsync), ev);
      check(de === 1'(ed), "R4/R5 de", int'(de), ed);
      check(int'(px_x) == ex, "R4 px_x", int'(px_x), ex);
      check(int'(px_y) == ey, "R4 px_y", int'(px_y), ey);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int d, found, prev, rises;
    int targets[4];
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check(!hsync && !vsync && !de && !irq && px_x == 0 && px_y == 0 && !pclk,
          "R1 reset outputs", int'({hsync, vsync, de, irq, pclk}), 0);

    // Configuration A: divider bypassed, normal polarity
    hsw_f = 1; hbp_f = 0; ppl_f = 0; hfp_f = 2;
    vsw = 1; vbp = 2; lpp_f = 2; vfp = 1;
    div_f = 0; byp = 1; ihs = 0; ivs = 0; ioe = 0; ipc = 0;
    apply_cfg();
    rd(0, d); check(d == hword(), "R10 readback htim", d, hword());
    rd(1, d); check(d == vword(), "R10 readback vtim", d, vword());
    check(!hsync && !de && !pclk, "R1 disabled outputs", int'({hsync, de, pclk}), 0);

    wr(3, 1);
    sweep(2 * 22 * 7);
    // R6: bypass passes the input clock to the panel clock
    @(posedge clk); #1; check(pclk === 1'b1, "R6 bypass pclk high", int'(pclk), 1);
    @(negedge clk);      check(pclk === 1'b0, "R6 bypass pclk low", int'(pclk), 0);

    wr(3, 0);
    @(negedge clk);
    check(px_x == 0 && px_y == 0 && !de && !hsync && !vsync, "R1 after disable",
          int'({de, hsync, vsync}), 0);

    // R7: each vertical-compare phase, measured from a fresh enable
    targets[0] = 0; targets[1] = 1 * 22; targets[2] = 3 * 22; targets[3] = 6 * 22;
    wr(4, 32'h8);
    for (int md = 0; md < 4; md++) begin
      wr(3, 0);
      wr(5, 32'h1E);
      check(!irq, "R9 cleared before R7 run", int'(irq), 0);
      wr(3, (md << 12) | 1);
      found = -1;
      for (int m = 0; m < 400 && found < 0; m++) begin
        @(negedge clk);
        if (irq) found = m;
      end
      check(found == targets[md], "R7 vcomp phase sample", found, targets[md]);
    end
    wr(3, 0);
    wr(5, 32'h1E);

    // R8: external events and masking
    @(negedge clk); ev_bus_err = 1; ev_base_upd = 1; ev_underrun = 1;
    @(negedge clk); ev_bus_err = 0; ev_base_upd = 0; ev_underrun = 0;
    rd(5, d); check(d == 32'h16, "R8 raw status bits", d, 32'h16);
    rd(6, d); check(d == 0, "R8 masked with vcomp-only enable", d, 0);
    check(!irq, "R8 irq masked off", int'(irq), 0);
    wr(4, 32'h4);
    rd(6, d); check(d == 32'h4, "R8 masked status", d, 32'h4);
    check(irq, "R8 irq from masked bit", int'(irq), 1);

    // R9: write-one-to-clear and event priority
    wr(5, 32'h2);
    rd(5, d); check(d == 32'h14, "R9 clear bit1", d, 32'h14);
    wr(5, 32'h10);
    rd(5, d); check(d == 32'h4, "R9 clear bit4", d, 32'h4);
    @(negedge clk); ev_bus_err = 1; reg_we = 1; reg_addr = 3'd5; reg_wdata = 32'h10;
    @(negedge clk); ev_bus_err = 0; reg_we = 0;
    rd(5, d); check(d == 32'h14, "R9 event beats clear", d, 32'h14);

    // Configuration B: divider ratio 2, all polarities inverted, zero-length vertical phases
    hsw_f = 0; hbp_f = 1; ppl_f = 0; hfp_f = 0;
    vsw = 0; vbp = 1; lpp_f = 1; vfp = 0;
    div_f = 0; byp = 0; ihs = 1; ivs = 1; ioe = 1; ipc = 1;
    apply_cfg();
    @(negedge clk);
    check(hsync && vsync && de && pclk, "R5 inverted idle levels", int'({hsync, vsync, de, pclk}), 15);
    wr(3, 1);
    sweep(2 * 20 * 3);
    // R6: panel clock period equals the divide ratio
    @(negedge clk); prev = int'(pclk); rises = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (prev == 0 && pclk) rises++;
      prev = int'(pclk);
    end
    check(rises == 10, "R6 divided pclk rises", rises, 10);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule